// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block builds processor exception frames on the supervisor stack and takes them apart again. It has a single memory port that carries word and longword accesses. On an entry request it samples the interrupted status word, the return PC, an optional fault address, a vector number, a 4-bit frame format code and the stack pointers. It then writes the frame downward from the aligned stack pointer. After the frame is written it reads the handler address from the vector table and reports the new PC, the new status word and the new stack pointer.

On a return request it reads a frame upward from the given stack pointer and recovers the status word and the PC. The format code found in the frame tells it how many more bytes to discard. A format-1 frame marks a throwaway frame: the sequencer applies that frame's status and then reads a second frame from the stack pointer where the first one ended. A hardware interrupt taken while the master bit is set produces two frames. The first is a format-0 frame on the current stack. The second is a format-1 frame on the interrupt stack.

The port holds each request until the memory accepts it. Word data travels on bits 15:0, and the memory is big-endian (most significant byte at the lowest address).

Top module: `exc_frame_seq`

## Requirements
- R1: While reset is low and right after it, busy, done and mem_valid are 0 and pc_out, sr_out, sp_out and sp_prev_out are 0.
- R2: A word access uses mem_be = 4'b0011 with data on bits 15:0; a longword access uses mem_be = 4'b1111. Address, data, byte enables and direction stay unchanged while mem_valid is high and mem_ready is low.
- R3: The format/vector word written to the frame equals (format << 12) + (vector * 4).
- R4: Frames are pushed downward in this order: extra longwords, format/vector word, return PC longword, and the status word at the lowest address. Formats 2 and 3 add one extra longword holding the fault address. Format 4 pushes the PC longword first and then the fault address longword. Every other code adds no extra longwords.
- R5: With UNALIGNED_OK = 0 (the default), bit 0 of each stack pointer is cleared before the frame is pushed.
- R6: On entry the reported status has bit 13 (supervisor) set and bit 15 (trace) clear. For a hardware interrupt, bits 10:8 are replaced with the request level; otherwise they are left unchanged.
- R7: After the frame is written, a longword is read from vbr_in + vector * 4. It is returned as pc_out, and sp_out is the stack pointer after the last push.
- R8: A return reads the status word (+2), then the PC longword (+4), then the format/vector word (+2). It then adds 4 bytes for format 2 or 3, 8 for format 4, 52 for format 7 and 0 for any other code. No write is issued during a return.
- R9: When the format/vector word read during a return has format 1, reading restarts from the stack pointer just past it. The reported PC and status come from the second frame.
- R10: A hardware interrupt whose old status has bit 12 (master) set first writes a format-0 frame holding the old status on sp_in. It then writes a format-1 frame holding the new status (bit 12 still set) on isp_in. The reported status has bit 12 cleared, sp_out is the interrupt stack after its frame, and sp_prev_out is the first stack after its frame. In all other cases sp_prev_out equals sp_out.
- R11: busy is high from the cycle after a request is accepted until the final access completes. done is then high for exactly one cycle with busy low. The outputs hold their values until the next done.
- R12: An entry request wins over a return request in the same cycle. Requests are ignored while busy or done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| entry_req | input | 1 | Start exception entry (sampled when idle) |
| ret_req | input | 1 | Start return from exception (sampled when idle) |
| old_sr_in | input | 16 | Status word at the time of the exception |
| ret_pc_in | input | ADDR_W | Return PC pushed in the frame |
| fault_addr_in | input | ADDR_W | Address stored in format 2/3/4 frames |
| vec_in | input | 8 | Vector number |
| fmt_in | input | 4 | Frame format code |
| hw_irq_in | input | 1 | Entry is a hardware interrupt |
| irq_level_in | input | 3 | Pending interrupt level |
| sp_in | input | ADDR_W | Active stack pointer |
| isp_in | input | ADDR_W | Interrupt stack pointer for the second frame |
| vbr_in | input | ADDR_W | Vector table base |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_be | output | 4 | 4'b0011 word, 4'b1111 longword |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | ADDR_W | Handler PC (entry) or restored PC (return) |
| sr_out | output | 16 | New or restored status word |
| sp_out | output | ADDR_W | Final stack pointer |
| sp_prev_out | output | ADDR_W | First stack after a two-frame entry |

## Verification
The assertions rely on three things about the memory. It returns read data in the same cycle it raises mem_ready. It raises mem_ready eventually. It does not need the request to change while it is stalling.

The bench memory model drives mem_ready from a repeating pattern that stalls one cycle in four, so some accesses are held across a wait cycle. It decodes only the byte enable codes of R2.

The stack pointers and vector table are placed inside the modelled range so that no frame overlaps the vectors. Requests are driven on the falling edge and only while the sequencer is idle. The one exception is the deliberate mid-operation request that checks it is ignored.

// File: rtl/exc_frame_pkg.sv
// Package: shared constants and types for the exception frame sequencer.
// Assumes a 16-bit status word and big-endian 32-bit longword accesses.
package exc_frame_pkg;

    localparam int SR_W       = 16;
    localparam int DATA_W     = 32;
    localparam int FMT_W      = 4;
    localparam int VEC_W      = 8;
    localparam int IPL_W      = 3;
    localparam int BE_W       = DATA_W / 8;
    localparam int SKIP_W     = 6;

    // status word bit positions
    localparam int SR_T_BIT   = 15;
    localparam int SR_S_BIT   = 13;
    localparam int SR_M_BIT   = 12;
    localparam int SR_IPL_LO  = 8;

    // push slots, highest address first
    localparam int N_SLOTS    = 5;
    localparam int SLOT_W     = 3;
    localparam logic [SLOT_W-1:0] SLOT_XPC  = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_XADR = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_FV   = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_RPC  = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_SR   = 3'd4;

    // pop slots, lowest address first
    localparam logic [SLOT_W-1:0] POP_SR    = 3'd0;
    localparam logic [SLOT_W-1:0] POP_PC    = 3'd1;
    localparam logic [SLOT_W-1:0] POP_FV    = 3'd2;

    localparam logic [BE_W-1:0] BE_WORD = 4'b0011;
    localparam logic [BE_W-1:0] BE_LONG = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_VFETCH,
        ST_POP,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/exc_frame_plan.sv
// Frame planner: turns a format code into the set of slots that are pushed
// and the number of trailing bytes skipped on return. Purely combinational.
// Assumes formats other than 1, 2, 3, 4 and 7 carry no extra data.
module exc_frame_plan
    import exc_frame_pkg::*;
(
    input  logic [FMT_W-1:0]   fmt,
    output logic [N_SLOTS-1:0] push_mask,
    output logic [SKIP_W-1:0]  pop_skip,
    output logic               is_chain
);

    // slot selection for pushes
    always_comb begin
        push_mask            = '0;
        push_mask[SLOT_XPC]  = (fmt == 4'd4);
        push_mask[SLOT_XADR] = (fmt == 4'd2) || (fmt == 4'd3) || (fmt == 4'd4);
        push_mask[SLOT_FV]   = 1'b1;
        push_mask[SLOT_RPC]  = 1'b1;
        push_mask[SLOT_SR]   = 1'b1;
    end

    // bytes discarded after the format/vector word on return
    always_comb begin
        case (fmt)
            4'd2, 4'd3: pop_skip = SKIP_W'(4);
            4'd4:       pop_skip = SKIP_W'(8);
            4'd7:       pop_skip = SKIP_W'(52);
            default:    pop_skip = '0;
        endcase
    end

    assign is_chain = (fmt == 4'd1);

endmodule

// File: rtl/exc_frame_status.sv
// Status builder: derives the entry status from the interrupted status.
// Sets supervisor, clears trace, loads the level for hardware interrupts
// and flags the two-frame master-stack case.
module exc_frame_status
    import exc_frame_pkg::*;
(
    input  logic [SR_W-1:0]  old_sr,
    input  logic             hw_irq,
    input  logic [IPL_W-1:0] level,
    output logic [SR_W-1:0]  entry_sr,
    output logic [SR_W-1:0]  final_sr,
    output logic             master_path
);

    // new status as written into a second frame
    always_comb begin
        entry_sr           = old_sr;
        entry_sr[SR_S_BIT] = 1'b1;
        entry_sr[SR_T_BIT] = 1'b0;
        if (hw_irq) begin
            entry_sr[SR_IPL_LO +: IPL_W] = level;
        end
    end

    // master bit drop for the two-frame case
    always_comb begin
        master_path = hw_irq && old_sr[SR_M_BIT];
        final_sr    = entry_sr;
        if (master_path) begin
            final_sr[SR_M_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_frame_seq.sv
// Exception frame sequencer (top). Pushes an exception frame, fetches the
// handler vector, or pops one or two frames on return. One memory access per
// handshake; the request is driven from state and so stays stable until
// mem_ready. Assumes mem_rdata is valid in the cycle mem_ready is high.
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter bit UNALIGNED_OK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              entry_req,
    input  logic              ret_req,
    input  logic [15:0]       old_sr_in,
    input  logic [ADDR_W-1:0] ret_pc_in,
    input  logic [ADDR_W-1:0] fault_addr_in,
    input  logic [7:0]        vec_in,
    input  logic [3:0]        fmt_in,
    input  logic              hw_irq_in,
    input  logic [2:0]        irq_level_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] isp_in,
    input  logic [ADDR_W-1:0] vbr_in,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [3:0]        mem_be,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [15:0]       sr_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [ADDR_W-1:0] sp_prev_out
);

    localparam logic [ADDR_W-1:0] BYTES_W = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] BYTES_L = ADDR_W'(4);

    seq_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic              second;
    logic              master_r;
    logic [SR_W-1:0]   frm_sr;
    logic [SR_W-1:0]   entry_sr_r;
    logic [SR_W-1:0]   final_sr_r;
    logic [ADDR_W-1:0] retpc_r;
    logic [ADDR_W-1:0] faddr_r;
    logic [VEC_W-1:0]  vec_r;
    logic [FMT_W-1:0]  fmt_r;
    logic [ADDR_W-1:0] isp_r;
    logic [ADDR_W-1:0] vbr_r;
    logic [ADDR_W-1:0] sp_w;
    logic [ADDR_W-1:0] sp_first;
    logic [SR_W-1:0]   pop_sr;
    logic [ADDR_W-1:0] pop_pc;

    logic [N_SLOTS-1:0] push_mask;
    logic [SKIP_W-1:0]  push_skip_unused;
    logic               push_chain_unused;
    logic [N_SLOTS-1:0] pop_mask_unused;
    logic [SKIP_W-1:0]  pop_skip;
    logic               pop_chain;

    logic [SR_W-1:0]    st_entry_sr;
    logic [SR_W-1:0]    st_final_sr;
    logic               st_master;

    logic [ADDR_W-1:0]  sp_in_al;
    logic [ADDR_W-1:0]  isp_al;
    logic               acc_long;
    logic [ADDR_W-1:0]  acc_bytes;
    logic               fire;
    logic [ADDR_W-1:0]  pop_end_sp;

    // planner for the frame being pushed
    exc_frame_plan u_plan_push (
        .fmt       (fmt_r),
        .push_mask (push_mask),
        .pop_skip  (push_skip_unused),
        .is_chain  (push_chain_unused)
    );

    // planner fed straight from the format/vector word being read
    exc_frame_plan u_plan_pop (
        .fmt       (mem_rdata[15:12]),
        .push_mask (pop_mask_unused),
        .pop_skip  (pop_skip),
        .is_chain  (pop_chain)
    );

    // entry status derived from the request operands
    exc_frame_status u_status (
        .old_sr      (old_sr_in),
        .hw_irq      (hw_irq_in),
        .level       (irq_level_in),
        .entry_sr    (st_entry_sr),
        .final_sr    (st_final_sr),
        .master_path (st_master)
    );

    // stack alignment variant chosen by parameter
    generate
        if (UNALIGNED_OK) begin : g_any_align
            assign sp_in_al = sp_in;
            assign isp_al   = isp_r;
        end else begin : g_even_align
            assign sp_in_al = {sp_in[ADDR_W-1:1], 1'b0};
            assign isp_al   = {isp_r[ADDR_W-1:1], 1'b0};
        end
    endgenerate

    // access size for the current step
    always_comb begin
        case (state)
            ST_PUSH:   acc_long = (slot != SLOT_FV) && (slot != SLOT_SR);
            ST_POP:    acc_long = (slot == POP_PC);
            ST_VFETCH: acc_long = 1'b1;
            default:   acc_long = 1'b0;
        endcase
    end
    assign acc_bytes = acc_long ? BYTES_L : BYTES_W;

    // memory request, driven from state so it holds until accepted
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH: begin
                mem_valid = push_mask[slot];
                mem_write = 1'b1;
                mem_addr  = sp_w - acc_bytes;
                case (slot)
                    SLOT_XPC, SLOT_RPC: mem_wdata = DATA_W'(retpc_r);
                    SLOT_XADR:          mem_wdata = DATA_W'(faddr_r);
                    SLOT_FV:            mem_wdata = {16'h0000, fmt_r, 2'b00, vec_r, 2'b00};
                    default:            mem_wdata = {16'h0000, frm_sr};
                endcase
            end
            ST_VFETCH: begin
                mem_valid = 1'b1;
                mem_addr  = vbr_r + ADDR_W'({vec_r, 2'b00});
            end
            ST_POP: begin
                mem_valid = 1'b1;
                mem_addr  = sp_w;
            end
            default: ;
        endcase
        mem_be = mem_valid ? (acc_long ? BE_LONG : BE_WORD) : '0;
    end

    assign fire       = mem_valid && mem_ready;
    assign pop_end_sp = sp_w + BYTES_W + ADDR_W'(pop_skip);
    assign busy       = (state == ST_PUSH) || (state == ST_VFETCH) || (state == ST_POP);
    assign done       = (state == ST_DONE);

    // sequencer state, working registers and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            slot        <= '0;
            second      <= 1'b0;
            master_r    <= 1'b0;
            frm_sr      <= '0;
            entry_sr_r  <= '0;
            final_sr_r  <= '0;
            retpc_r     <= '0;
            faddr_r     <= '0;
            vec_r       <= '0;
            fmt_r       <= '0;
            isp_r       <= '0;
            vbr_r       <= '0;
            sp_w        <= '0;
            sp_first    <= '0;
            pop_sr      <= '0;
            pop_pc      <= '0;
            pc_out      <= '0;
            sr_out      <= '0;
            sp_out      <= '0;
            sp_prev_out <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    slot   <= '0;
                    second <= 1'b0;
                    if (entry_req) begin
                        master_r   <= st_master;
                        frm_sr     <= old_sr_in;
                        entry_sr_r <= st_entry_sr;
                        final_sr_r <= st_final_sr;
                        retpc_r    <= ret_pc_in;
                        faddr_r    <= fault_addr_in;
                        vec_r      <= vec_in;
                        fmt_r      <= st_master ? '0 : fmt_in;
                        isp_r      <= isp_in;
                        vbr_r      <= vbr_in;
                        sp_w       <= sp_in_al;
                        state      <= ST_PUSH;
                    end else if (ret_req) begin
                        sp_w  <= sp_in;
                        state <= ST_POP;
                    end
                end
                ST_PUSH: begin
                    if (!push_mask[slot]) begin
                        slot <= slot + 1'b1;
                    end else if (fire) begin
                        if (slot != SLOT_SR) begin
                            sp_w <= sp_w - acc_bytes;
                            slot <= slot + 1'b1;
                        end else if (master_r && !second) begin
                            second   <= 1'b1;
                            sp_first <= sp_w - acc_bytes;
                            sp_w     <= isp_al;
                            fmt_r    <= 4'd1;
                            frm_sr   <= entry_sr_r;
                            slot     <= '0;
                        end else begin
                            sp_w  <= sp_w - acc_bytes;
                            state <= ST_VFETCH;
                        end
                    end
                end
                ST_VFETCH: begin
                    if (fire) begin
                        pc_out      <= ADDR_W'(mem_rdata);
                        sr_out      <= final_sr_r;
                        sp_out      <= sp_w;
                        sp_prev_out <= second ? sp_first : sp_w;
                        state       <= ST_DONE;
                    end
                end
                ST_POP: begin
                    if (fire) begin
                        case (slot)
                            POP_SR: begin
                                pop_sr <= mem_rdata[SR_W-1:0];
                                sp_w   <= sp_w + BYTES_W;
                                slot   <= POP_PC;
                            end
                            POP_PC: begin
                                pop_pc <= ADDR_W'(mem_rdata);
                                sp_w   <= sp_w + BYTES_L;
                                slot   <= POP_FV;
                            end
                            default: begin
                                if (pop_chain) begin
                                    sp_w <= sp_w + BYTES_W;
                                    slot <= POP_SR;
                                end else begin
                                    sp_w        <= pop_end_sp;
                                    pc_out      <= pop_pc;
                                    sr_out      <= pop_sr;
                                    sp_out      <= pop_end_sp;
                                    sp_prev_out <= pop_end_sp;
                                    state       <= ST_DONE;
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/exc_frame_seq_chk.sv
// Checker for the exception frame sequencer, bound to the top module.
// Watches the memory port, the busy/done handshake and the entry status.
module exc_frame_seq_chk #(
    parameter int ADDR_W       = 32,
    parameter bit UNALIGNED_OK = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              entry_req,
    input logic              ret_req,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [3:0]        mem_be,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              busy,
    input logic              done,
    input logic [15:0]       sr_out
);

    logic accept;
    logic mode_entry;

    assign accept = !busy && !done && (entry_req || ret_req);

    // remembers whether the running operation is an entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_entry <= 1'b0;
        end else if (accept) begin
            mode_entry <= entry_req;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
        $stable(mem_wdata) && $stable(mem_be) && $stable(mem_write));

    p_be_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_be == 4'b0011) || (mem_be == 4'b1111));

    p_even_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (UNALIGNED_OK == 1'b0) && mem_valid && mem_write |-> !mem_addr[0]);

    p_entry_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && mode_entry |-> sr_out[13] && !sr_out[15]);

    p_no_write_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mode_entry |-> !mem_write);

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_valid);

endmodule

bind exc_frame_seq exc_frame_seq_chk #(
    .ADDR_W       (ADDR_W),
    .UNALIGNED_OK (UNALIGNED_OK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_req (entry_req),
    .ret_req   (ret_req),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .sr_out    (sr_out)
);

// File: tb/test_exc_frame_seq.sv
`timescale 1ns/1ps
module test_exc_frame_seq;

    typedef struct packed {
        logic [3:0]  fmt;
        logic [7:0]  vec;
        logic [15:0] sr;
        logic [31:0] pc;
        logic [31:0] addr;
        logic [31:0] sp;
        logic        hw;
        logic [2:0]  lvl;
    } vec_t;

    localparam int   NV  = 6;
    localparam logic [31:0] VBR = 32'h0000_0100;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 8'h04, 16'h0000, 32'h0000_1000, 32'h0000_0000, 32'h0000_0F00, 1'b0, 3'd0},
        '{4'h2, 8'h05, 16'h8010, 32'h2222_0000, 32'h1234_5678, 32'h0000_0E01, 1'b0, 3'd0},
        '{4'h3, 8'h37, 16'h2700, 32'h3333_0004, 32'hDEAD_BEEC, 32'h0000_0D00, 1'b0, 3'd0},
        '{4'h4, 8'h03, 16'h0004, 32'h4444_0008, 32'hCAFE_0010, 32'h0000_0C02, 1'b0, 3'd0},
        '{4'h0, 8'h1A, 16'h0300, 32'h5555_000C, 32'h0000_0000, 32'h0000_0B00, 1'b1, 3'd5},
        '{4'h9, 8'h40, 16'h001F, 32'h6666_0010, 32'h0000_0000, 32'h0000_0A00, 1'b0, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        entry_req = 1'b0, ret_req = 1'b0;
    logic [15:0] old_sr_in = '0;
    logic [31:0] ret_pc_in = '0, fault_addr_in = '0;
    logic [7:0]  vec_in = '0;
    logic [3:0]  fmt_in = '0;
    logic        hw_irq_in = 1'b0;
    logic [2:0]  irq_level_in = '0;
    logic [31:0] sp_in = '0, isp_in = '0, vbr_in = VBR;
    logic        mem_valid, mem_write, mem_ready = 1'b1;
    logic [3:0]  mem_be;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done;
    logic [31:0] pc_out, sp_out, sp_prev_out;
    logic [15:0] sr_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [7:0] mem [4096];
    logic [1:0] rdy_cnt = '0;

    exc_frame_seq i_exc_frame_seq (
        .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .ret_req(ret_req),
        .old_sr_in(old_sr_in), .ret_pc_in(ret_pc_in), .fault_addr_in(fault_addr_in),
        .vec_in(vec_in), .fmt_in(fmt_in), .hw_irq_in(hw_irq_in),
        .irq_level_in(irq_level_in), .sp_in(sp_in), .isp_in(isp_in), .vbr_in(vbr_in),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_be(mem_be),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done), .pc_out(pc_out),
        .sr_out(sr_out), .sp_out(sp_out), .sp_prev_out(sp_prev_out)
    );

    always #10 clk = ~clk;

    // memory stalls one cycle in four
    always @(negedge clk) begin
        rdy_cnt   <= rdy_cnt + 2'd1;
        mem_ready <= (rdy_cnt != 2'd2);
    end

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return {mem[a[11:0]], mem[a[11:0]+12'd1], mem[a[11:0]+12'd2], mem[a[11:0]+12'd3]};
    endfunction

    function automatic logic [15:0] rd16(input logic [31:0] a);
        return {mem[a[11:0]], mem[a[11:0]+12'd1]};
    endfunction

    always_comb begin
        if (mem_be == 4'b1111) mem_rdata = rd32(mem_addr);
        else                   mem_rdata = {16'h0000, rd16(mem_addr)};
    end

    // big-endian memory writes
    always @(posedge clk) begin
        if (mem_valid && mem_ready && mem_write) begin
            if (mem_be == 4'b1111) begin
                mem[mem_addr[11:0]]       <= mem_wdata[31:24];
                mem[mem_addr[11:0]+12'd1] <= mem_wdata[23:16];
                mem[mem_addr[11:0]+12'd2] <= mem_wdata[15:8];
                mem[mem_addr[11:0]+12'd3] <= mem_wdata[7:0];
            end else begin
                mem[mem_addr[11:0]]       <= mem_wdata[15:8];
                mem[mem_addr[11:0]+12'd1] <= mem_wdata[7:0];
            end
        end
    end

    task automatic wr32(input logic [31:0] a, input logic [31:0] d);
        mem[a[11:0]] = d[31:24]; mem[a[11:0]+12'd1] = d[23:16];
        mem[a[11:0]+12'd2] = d[15:8]; mem[a[11:0]+12'd3] = d[7:0];
    endtask

    task automatic wr16(input logic [31:0] a, input logic [15:0] d);
        mem[a[11:0]] = d[15:8]; mem[a[11:0]+12'd1] = d[7:0];
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic wait_done;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (done) break;
        end
        chk("R11 done seen", {31'd0, done}, 32'd1);
    endtask

    task automatic do_entry(input vec_t v, input logic [31:0] isp, input bit also_ret);
        @(negedge clk);
        fmt_in = v.fmt; vec_in = v.vec; old_sr_in = v.sr; ret_pc_in = v.pc;
        fault_addr_in = v.addr; sp_in = v.sp; hw_irq_in = v.hw;
        irq_level_in = v.lvl; isp_in = isp;
        entry_req = 1'b1; ret_req = also_ret;
        @(negedge clk);
        entry_req = 1'b0; ret_req = 1'b0;
        chk("R11 busy after accept", {31'd0, busy}, 32'd1);
        wait_done();
    endtask

    task automatic do_return(input logic [31:0] sp);
        @(negedge clk);
        sp_in = sp; ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        wait_done();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < 256; v++) wr32(VBR + 32'(v * 4), 32'hA000_0000 | 32'(v));

        // reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
        chk("R1 pc_out", pc_out, 32'd0);
        chk("R1 sp_out", sp_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {30'd0, busy, done}, 32'd0);

        // table of entry and round-trip return vectors
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] sp0, spe, extra;
            logic [15:0] sre;
            v = VECS[i];
            sp0   = {v.sp[31:1], 1'b0};
            extra = (v.fmt == 4'h2 || v.fmt == 4'h3) ? 32'd4 : (v.fmt == 4'h4) ? 32'd8 : 32'd0;
            spe   = sp0 - 32'd8 - extra;
            sre   = (v.sr | 16'h2000) & 16'h7FFF;
            if (v.hw) sre[10:8] = v.lvl;
            do_entry(v, 32'h0, 1'b0);
            chk("R5 R7 sp_out", sp_out, spe);
            chk("R10 sp_prev_out single", sp_prev_out, spe);
            chk("R6 sr_out", {16'd0, sr_out}, {16'd0, sre});
            chk("R7 handler pc", pc_out, 32'hA000_0000 | 32'(v.vec));
            chk("R4 frame sr", {16'd0, rd16(spe)}, {16'd0, v.sr});
            chk("R4 frame pc", rd32(spe + 32'd2), v.pc);
            chk("R3 fv word", {16'd0, rd16(spe + 32'd6)}, {16'd0, v.fmt, 2'b00, v.vec, 2'b00});
            if (extra != 0) chk("R4 fault addr", rd32(spe + 32'd8), v.addr);
            if (v.fmt == 4'h4) chk("R4 fmt4 pc", rd32(spe + 32'd12), v.pc);
            do_return(spe);
            chk("R8 ret pc", pc_out, v.pc);
            chk("R8 ret sr", {16'd0, sr_out}, {16'd0, v.sr});
            chk("R8 ret sp", sp_out, sp0);
        end

        // done lasts one cycle
        @(negedge clk);
        chk("R11 done single cycle", {31'd0, done}, 32'd0);

        // format 7 return skips 52 bytes
        wr16(32'h500, 16'h2015); wr32(32'h502, 32'h7777_0000); wr16(32'h506, 16'h7008);
        do_return(32'h500);
        chk("R8 fmt7 sp", sp_out, 32'h53C);
        chk("R8 fmt7 pc", pc_out, 32'h7777_0000);

        // throwaway frame followed by a normal frame
        wr16(32'h600, 16'h3300); wr32(32'h602, 32'h1111_0000); wr16(32'h606, 16'h1064);
        wr16(32'h608, 16'h0404); wr32(32'h60A, 32'h4444_0000); wr16(32'h60E, 16'h0010);
        do_return(32'h600);
        chk("R9 chained sr", {16'd0, sr_out}, 32'h0404);
        chk("R9 chained pc", pc_out, 32'h4444_0000);
        chk("R9 chained sp", sp_out, 32'h610);

        // hardware interrupt with master bit set: two frames
        do_entry('{4'h0, 8'h19, 16'h1000, 32'h8888_0000, 32'h0, 32'h900, 1'b1, 3'd3}, 32'h7FF, 1'b0);
        chk("R10 sr_out M cleared", {16'd0, sr_out}, 32'h2300);
        chk("R10 sp_out", sp_out, 32'h7F6);
        chk("R10 sp_prev_out", sp_prev_out, 32'h8F8);
        chk("R10 first frame sr", {16'd0, rd16(32'h8F8)}, 32'h1000);
        chk("R10 first frame fv", {16'd0, rd16(32'h8FE)}, 32'h0064);
        chk("R10 second frame sr", {16'd0, rd16(32'h7F6)}, 32'h3300);
        chk("R10 second frame pc", rd32(32'h7F8), 32'h8888_0000);
        chk("R10 second frame fv", {16'd0, rd16(32'h7FC)}, 32'h1064);

        // both requests: entry wins
        do_entry('{4'h0, 8'h08, 16'h0000, 32'h9999_0000, 32'h0, 32'h880, 1'b0, 3'd0}, 32'h0, 1'b1);
        chk("R12 entry priority sp", sp_out, 32'h878);
        chk("R12 entry priority pc", pc_out, 32'hA000_0008);

        // request while busy is ignored
        @(negedge clk);
        fmt_in = 4'h0; vec_in = 8'h09; old_sr_in = 16'h0; ret_pc_in = 32'h1;
        sp_in = 32'h840; hw_irq_in = 1'b0; entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        @(negedge clk);
        ret_req = 1'b1; sp_in = 32'h500;
        @(negedge clk);
        ret_req = 1'b0;
        wait_done();
        repeat (3) @(negedge clk);
        chk("R12 ignored while busy: stays idle", {31'd0, busy}, 32'd0);
        chk("R12 ignored while busy: pc held", pc_out, 32'hA000_0009);
        chk("R12 ignored while busy: sp held", sp_out, 32'h838);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule